// File: doc/BRIEF.md
# Iterative Integer Divide Unit

This block computes the four 32-bit integer divide operations of a RISC-V M-extension datapath: signed quotient, unsigned quotient, signed remainder and unsigned remainder. A one-cycle start strobe supplies the dividend, the divisor and a two-bit operation code. The unit raises `busy_o` while it works, pulses `done_o` for one cycle and presents the answer on `result_o`. The answer stays there until the next completion.

The datapath first turns both operands into unsigned magnitudes. A restoring shift-subtract loop then forms one quotient bit per clock, and the signs are applied to the quotient or the remainder at the end. Division by zero and the single signed overflow case never trap. Both are recognised when the operation is accepted and answered on the next edge without entering the loop.

Top module: `rvdiv_unit`

## Requirements
- R1: With `op_i` = 0 (DIV) the result is the signed quotient truncated toward zero (46 / 10 = 4, -46 / 10 = -4).
- R2: With `op_i` = 2 (REM) the result is the signed remainder that pairs with the truncated quotient and has the sign of the dividend (46 rem 10 = 6, -46 rem 10 = -6).
- R3: With `op_i` = 1 (DIVU) and `op_i` = 3 (REMU) both operands are treated as unsigned.
- R4: A zero divisor raises no error. The quotient forms return all ones and the remainder forms return the dividend. `done_o` is high in the cycle after the accepting edge, and `busy_o` stays low.
- R5: For signed overflow (dividend 0x80000000, divisor 0xFFFFFFFF, with op 0 or 2), DIV returns 0x80000000 and REM returns 0. Both complete on the next edge, as in R4.
- R6: Any other operation raises `busy_o` after the accepting edge and keeps it high for 33 cycles. `done_o` is then high for exactly one cycle, the one after the 33rd rising edge that follows acceptance, and `busy_o` is low in that cycle.
- R7: A `start_i` that arrives while `busy_o` is high is ignored. The running operation keeps its result and its timing, and no extra `done_o` appears.
- R8: After reset `busy_o`, `done_o` and `result_o` are zero. `result_o` changes only in a cycle where `done_o` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation request, sampled while idle |
| op_i | input | 2 | 0 DIV, 1 DIVU, 2 REM, 3 REMU |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| busy_o | output | 1 | Loop in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Quotient or remainder, held between completions |

## Verification
A new request and the completion of the previous one can fall in the same cycle. The unit goes idle in the cycle where `done_o` is high, so it accepts a start presented alongside that pulse. The bench provokes this on every vector. It raises the next `start_i` in the very cycle it observes `done_o`, so fast zero-divisor requests and full-length loops follow each other with no gap. Each operation is judged by its own result and its own edge count, and neither may be lost or delayed.

// File: rtl/rvdiv_pkg.sv
package rvdiv_pkg;
   typedef enum logic [1:0] {
      OP_DIV  = 2'd0,
      OP_DIVU = 2'd1,
      OP_REM  = 2'd2,
      OP_REMU = 2'd3
   } div_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } div_state_e;
endpackage

// File: rtl/rvdiv_prep.sv
// Operand conditioning: magnitudes, sign plan and the no-loop special cases.
module rvdiv_prep import rvdiv_pkg::*; #(
   parameter int XLEN = 32
) (
   input  logic [1:0]      op_i,
   input  logic [XLEN-1:0] dividend_i,
   input  logic [XLEN-1:0] divisor_i,
   output logic [XLEN-1:0] mag_a_o,
   output logic [XLEN-1:0] mag_b_o,
   output logic            is_rem_o,
   output logic            neg_quo_o,
   output logic            neg_rem_o,
   output logic            special_o,
   output logic [XLEN-1:0] special_res_o
);
   localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

   div_op_e op;
   logic    is_signed, neg_a, neg_b, div_zero, overflow;

   assign op        = div_op_e'(op_i);
   assign is_signed = (op == OP_DIV) || (op == OP_REM);
   assign is_rem_o  = (op == OP_REM) || (op == OP_REMU);

   assign neg_a = is_signed & dividend_i[XLEN-1];
   assign neg_b = is_signed & divisor_i[XLEN-1];

   assign mag_a_o = neg_a ? (~dividend_i + 1'b1) : dividend_i;
   assign mag_b_o = neg_b ? (~divisor_i + 1'b1) : divisor_i;

   assign neg_quo_o = neg_a ^ neg_b;
   assign neg_rem_o = neg_a;

   assign div_zero  = (divisor_i == '0);
   assign overflow  = is_signed && (dividend_i == MOST_NEG) && (&divisor_i);
   assign special_o = div_zero | overflow;

   always_comb begin
      if (div_zero)
         special_res_o = is_rem_o ? dividend_i : '1;
      else
         special_res_o = is_rem_o ? '0 : MOST_NEG;
   end
endmodule

// File: rtl/rvdiv_core.sv
// Restoring shift-subtract loop on magnitudes, one quotient bit per step.
module rvdiv_core #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            step_i,
   input  logic [XLEN-1:0] mag_a_i,
   input  logic [XLEN-1:0] mag_b_i,
   output logic [XLEN-1:0] quo_o,
   output logic [XLEN-1:0] rem_o,
   output logic            last_o
);
   localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1;
   localparam logic [CW-1:0] LAST_STEP = CW'(XLEN - 1);

   logic [XLEN-1:0] quo_q, rem_q, div_q;
   logic [CW-1:0]   cnt_q;
   logic [XLEN:0]   shifted, trial;

   assign shifted = {rem_q, quo_q[XLEN-1]};
   assign trial   = shifted - {1'b0, div_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q <= '0;
         rem_q <= '0;
         div_q <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         quo_q <= mag_a_i;
         rem_q <= '0;
         div_q <= mag_b_i;
         cnt_q <= '0;
      end else if (step_i) begin
         if (!trial[XLEN]) begin
            rem_q <= trial[XLEN-1:0];
            quo_q <= {quo_q[XLEN-2:0], 1'b1};
         end else begin
            rem_q <= shifted[XLEN-1:0];
            quo_q <= {quo_q[XLEN-2:0], 1'b0};
         end
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign quo_o  = quo_q;
   assign rem_o  = rem_q;
   assign last_o = step_i && (cnt_q == LAST_STEP);
endmodule

// File: rtl/rvdiv_fix.sv
// Sign application and selection of quotient or remainder.
module rvdiv_fix #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] quo_i,
   input  logic [XLEN-1:0] rem_i,
   input  logic            is_rem_i,
   input  logic            neg_quo_i,
   input  logic            neg_rem_i,
   output logic [XLEN-1:0] res_o
);
   logic [XLEN-1:0] quo_s, rem_s;

   assign quo_s = neg_quo_i ? (~quo_i + 1'b1) : quo_i;
   assign rem_s = neg_rem_i ? (~rem_i + 1'b1) : rem_i;
   assign res_o = is_rem_i ? rem_s : quo_s;
endmodule

// File: rtl/rvdiv_unit.sv
module rvdiv_unit import rvdiv_pkg::*; #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      op_i,
   input  logic [XLEN-1:0] dividend_i,
   input  logic [XLEN-1:0] divisor_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [XLEN-1:0] result_o
);
   generate
      if (XLEN < 4) begin : g_bad_xlen
         $error("rvdiv_unit: XLEN must be at least 4");
      end
   endgenerate

   div_state_e      state_q;
   logic            accept, done_q;
   logic            is_rem_q, neg_quo_q, neg_rem_q;
   logic [XLEN-1:0] result_q;

   logic [XLEN-1:0] mag_a, mag_b, special_res, quo, rem, fixed;
   logic            is_rem, neg_quo, neg_rem, special, last;

   assign accept = start_i && (state_q == ST_IDLE);

   rvdiv_prep #(.XLEN(XLEN)) i_prep (
      .op_i          (op_i),
      .dividend_i    (dividend_i),
      .divisor_i     (divisor_i),
      .mag_a_o       (mag_a),
      .mag_b_o       (mag_b),
      .is_rem_o      (is_rem),
      .neg_quo_o     (neg_quo),
      .neg_rem_o     (neg_rem),
      .special_o     (special),
      .special_res_o (special_res)
   );

   rvdiv_core #(.XLEN(XLEN)) i_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept && !special),
      .step_i  (state_q == ST_RUN),
      .mag_a_i (mag_a),
      .mag_b_i (mag_b),
      .quo_o   (quo),
      .rem_o   (rem),
      .last_o  (last)
   );

   rvdiv_fix #(.XLEN(XLEN)) i_fix (
      .quo_i     (quo),
      .rem_i     (rem),
      .is_rem_i  (is_rem_q),
      .neg_quo_i (neg_quo_q),
      .neg_rem_i (neg_rem_q),
      .res_o     (fixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         done_q    <= 1'b0;
         result_q  <= '0;
         is_rem_q  <= 1'b0;
         neg_quo_q <= 1'b0;
         neg_rem_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (special) begin
                     result_q <= special_res;
                     done_q   <= 1'b1;
                  end else begin
                     state_q   <= ST_RUN;
                     is_rem_q  <= is_rem;
                     neg_quo_q <= neg_quo;
                     neg_rem_q <= neg_rem;
                  end
               end
            end
            ST_RUN: begin
               if (last) state_q <= ST_FIN;
            end
            ST_FIN: begin
               result_q <= fixed;
               done_q   <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o   = (state_q != ST_IDLE);
   assign done_o   = done_q;
   assign result_o = result_q;
endmodule

// File: rtl/rvdiv_checker.sv
module rvdiv_checker #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic [1:0]      op_i,
   input logic [XLEN-1:0] dividend_i,
   input logic [XLEN-1:0] divisor_i,
   input logic            busy_o,
   input logic            done_o,
   input logic [XLEN-1:0] result_o
);
   localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

   logic take, zero_div, ovf;
   assign take     = start_i && !busy_o;
   assign zero_div = (divisor_i == '0);
   assign ovf      = !op_i[0] && (dividend_i == MOST_NEG) && (&divisor_i);

   AST_ZERO_DIV_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      (take && zero_div) |=> (done_o && !busy_o)); // R4
   AST_ZERO_DIV_QUO: assert property (@(posedge clk) disable iff (!rst_n)
      (take && zero_div && !op_i[1]) |=> (&result_o)); // R4
   AST_OVERFLOW_QUO: assert property (@(posedge clk) disable iff (!rst_n)
      (take && ovf && !op_i[1]) |=> (result_o == MOST_NEG)); // R5
   AST_LOOP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !zero_div && !ovf) |=> (busy_o && !done_o)); // R6
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o)); // R6
   AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> (busy_o || done_o)); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o)); // R8
endmodule

bind rvdiv_unit rvdiv_checker #(.XLEN(XLEN)) i_rvdiv_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .op_i       (op_i),
   .dividend_i (dividend_i),
   .divisor_i  (divisor_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .result_o   (result_o)
);

// File: tb/test_rvdiv_unit.sv
`timescale 1ns/1ps
module test_rvdiv_unit;
   localparam int NV = 22;
   localparam int LOOP_LAT = 33;

   // {op[1:0], dividend[31:0], divisor[31:0], expected[31:0]}
   localparam logic [97:0] VECS [0:NV-1] = '{
      {2'd0, 32'd46,         32'd10,         32'd4},
      {2'd2, 32'd46,         32'd10,         32'd6},
      {2'd0, 32'hFFFFFFD2,   32'd10,         32'hFFFFFFFC},
      {2'd2, 32'hFFFFFFD2,   32'd10,         32'hFFFFFFFA},
      {2'd0, 32'd46,         32'hFFFFFFF6,   32'hFFFFFFFC},
      {2'd2, 32'd46,         32'hFFFFFFF6,   32'd6},
      {2'd0, 32'hFFFFFFD2,   32'hFFFFFFF6,   32'd4},
      {2'd2, 32'hFFFFFFD2,   32'hFFFFFFF6,   32'hFFFFFFFA},
      {2'd0, 32'h80000000,   32'd2,          32'hC0000000},
      {2'd0, 32'h7FFFFFFF,   32'h7FFFFFFF,   32'd1},
      {2'd0, 32'd0,          32'd5,          32'd0},
      {2'd1, 32'hFFFFFFD2,   32'd10,         32'h19999995},
      {2'd3, 32'hFFFFFFFF,   32'd10,         32'd5},
      {2'd1, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF},
      {2'd3, 32'd7,          32'hFFFFFFF0,   32'd7},
      {2'd1, 32'h80000000,   32'hFFFFFFFF,   32'd0},
      {2'd0, 32'd46,         32'd0,          32'hFFFFFFFF},
      {2'd1, 32'd46,         32'd0,          32'hFFFFFFFF},
      {2'd2, 32'hFFFFFFD2,   32'd0,          32'hFFFFFFD2},
      {2'd3, 32'd123,        32'd0,          32'd123},
      {2'd0, 32'h80000000,   32'hFFFFFFFF,   32'h80000000},
      {2'd2, 32'h80000000,   32'hFFFFFFFF,   32'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [31:0] dividend_i = '0;
   logic [31:0] divisor_i = '0;
   logic        busy_o, done_o;
   logic [31:0] result_o;

   int checks = 0;
   int fails = 0;

   always #5 clk = ~clk;

   rvdiv_unit #(.XLEN(32)) i_rvdiv_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .op_i       (op_i),
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .result_o   (result_o)
   );

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [1:0] op, input logic [31:0] a,
                                    input logic [31:0] b);
      if (b == 0) return "R4";
      if (!op[0] && a == 32'h80000000 && b == 32'hFFFFFFFF) return "R5";
      if (op[0]) return "R3";
      return op[1] ? "R2" : "R1";
   endfunction

   // Called at a negedge; returns at the negedge where done_o is high.
   task automatic run_op(input logic [1:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] exp);
      int n;
      bit fast;
      fast = (b == 0) || (!op[0] && a == 32'h80000000 && b == 32'hFFFFFFFF);
      op_i = op; dividend_i = a; divisor_i = b; start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      if (!fast) check(busy_o && !done_o, "R6 busy after accept", {31'd0, busy_o}, 32'd1);
      while (!done_o && n < 100) begin
         @(posedge clk);
         @(negedge clk);
         n++;
      end
      check(result_o == exp, tag_of(op, a, b), result_o, exp);
      check(n == (fast ? 0 : LOOP_LAT), fast ? "R4/R5 latency" : "R6 latency",
            n, fast ? 0 : LOOP_LAT);
      check(!busy_o, "R6 idle with done", {31'd0, busy_o}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state
      check(!busy_o, "R8 reset busy", {31'd0, busy_o}, 32'd0);
      check(!done_o, "R8 reset done", {31'd0, done_o}, 32'd0);
      check(result_o == 0, "R8 reset result", result_o, 32'd0);

      // Table walk, back to back: next start in the cycle done is seen
      for (int i = 0; i < NV; i++)
         run_op(VECS[i][97:96], VECS[i][95:64], VECS[i][63:32], VECS[i][31:0]);

      // R8: result holds after completion
      held = result_o;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(!done_o, "R8 single done pulse", {31'd0, done_o}, 32'd0);
         check(result_o == held, "R8 result hold", result_o, held);
      end

      // R7: start while busy is ignored (a zero-divide request mid-loop)
      begin
         int n;
         op_i = 2'd0; dividend_i = 32'd100; divisor_i = 32'd7; start_i = 1'b1;
         @(posedge clk);
         @(negedge clk);
         start_i = 1'b0;
         n = 0;
         repeat (5) begin @(posedge clk); @(negedge clk); n++; end
         op_i = 2'd3; dividend_i = 32'd55; divisor_i = 32'd0; start_i = 1'b1;
         @(posedge clk);
         @(negedge clk);
         start_i = 1'b0;
         n++;
         check(!done_o && busy_o, "R7 no done from ignored start", {31'd0, done_o}, 32'd0);
         while (!done_o && n < 100) begin
            @(posedge clk);
            @(negedge clk);
            n++;
         end
         check(result_o == 32'd14, "R7 running result kept", result_o, 32'd14);
         check(n == LOOP_LAT, "R7 timing unchanged", n, LOOP_LAT);
      end

      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule